// File: doc/BRIEF.md
# Dual-Channel Display Mode Sequencer

This controller decides which of two input channels feeds the vertical path of a two-trace display. A group of five mode buttons chooses between showing one channel alone, showing the difference of the two, or sharing the display in time between them. The buttons sit on `mode_btn`: bit 0 selects channel 1 only, bit 1 selects channel 2 only, bit 2 selects difference, bit 3 selects alternate and bit 4 selects chop. Time sharing works in one of two ways. In chop mode the selection flips on a fixed internal cadence, and each flip raises a short blanking pulse that hides the switching glitch on the intensity path. In alternate mode the selection flips once for each end-of-sweep strobe.

A single selection flop carries the active channel in both time-shared modes. In chop mode a divider with a programmable terminal count advances it. In alternate mode the strobe advances it. The trigger source normally follows channel 1. Channel 2 becomes the trigger source when channel 2 is used on its own, or when its button is held together with a difference, alternate or chop button. Every output comes from a register.

Top module: `dual_trace_sequencer`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs after that edge are `ch1_en`=1, `ch2_en`=0, `ch2_inv`=0, `blank`=0 and `trig_ch2`=0.
- R2: With `mode_btn`=5'b00001, and also for any pattern that sets none of bits 2, 3 and 4 and is not exactly bit 1 alone (for example 5'b00000 or 5'b00011), only `ch1_en` is high and `ch2_inv` is low.
- R3: With bit 1 as the only set bit of `mode_btn`, only `ch2_en` is high, `ch2_inv` is low and `trig_ch2` is high.
- R4: When bit 2 (difference) is set, both enables and `ch2_inv` are high, whatever bits 3 and 4 hold.
- R5: In chop mode (bit 4 set, bits 2 and 3 clear), channel 1 is enabled first, and the enabled channel swaps every CHOP_DIV clock cycles.
- R6: In chop mode, `blank` rises on the same edge as each channel swap and stays high for exactly BLANK_W cycles.
- R7: In alternate mode (bit 3 set, bit 2 clear), the enabled channel swaps on the edge that samples `sweep_end` high, starting from channel 1, and `blank` stays low.
- R8: `sweep_end` has no effect on any output in any mode other than alternate.
- R9: `trig_ch2` is high exactly when bit 1 is set and the decoded mode is channel 2, difference, alternate or chop. Otherwise it is low.
- R10: On the edge where the decoded mode changes, the selection returns to channel 1, the chop divider restarts and `blank` drops. A swap due on that same edge does not take place.
- R11: When bits 3 and 4 are both set and bit 2 is clear, alternate behaviour applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_btn | input | 5 | Mode buttons: [0] ch1, [1] ch2, [2] diff, [3] alt, [4] chop |
| sweep_end | input | 1 | One-cycle end-of-sweep strobe |
| ch1_en | output | 1 | Channel 1 drives the vertical path |
| ch2_en | output | 1 | Channel 2 drives the vertical path |
| ch2_inv | output | 1 | Invert channel 2 (difference display) |
| blank | output | 1 | Intensity blanking pulse on chop swaps |
| trig_ch2 | output | 1 | Trigger source: 1 = channel 2, 0 = channel 1 |

## Verification
A mode change can land on the very cycle in which the chop divider reaches its terminal count. In the same way, a strobe can arrive on the cycle in which alternate mode is entered. The bench provokes the first case by leaving chop mode after every hold length from zero to one full chop period, so one of those runs must hit the terminal count exactly. It provokes the second case by raising `sweep_end` together with the button change. In both cases the reference model expects the mode change to win: channel 1 is enabled, there is no swap and `blank` is low. The outputs are compared against the model on every cycle.

// File: rtl/dual_trace_sequencer.sv
module dual_trace_sequencer #(
  parameter int CHOP_DIV = 500,
  parameter int BLANK_W  = 25
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [4:0] mode_btn,
  input  logic       sweep_end,
  output logic       ch1_en,
  output logic       ch2_en,
  output logic       ch2_inv,
  output logic       blank,
  output logic       trig_ch2
);
  localparam int DW = (CHOP_DIV > 2) ? $clog2(CHOP_DIV) : 1;
  localparam int BW = $clog2(BLANK_W + 1);

  typedef enum logic [2:0] {M_CH1, M_CH2, M_DIFF, M_ALT, M_CHOP} mode_t;

  mode_t          mode_q, mode_d;
  logic           sel_q, sel_d;
  logic [DW-1:0]  div_q, div_d;
  logic [BW-1:0]  bl_q, bl_d;
  logic           chg, tc, shared;

  always_comb begin
    if (mode_btn[2])                     mode_d = M_DIFF;
    else if (mode_btn[3])                mode_d = M_ALT;
    else if (mode_btn[4])                mode_d = M_CHOP;
    else if (mode_btn[1] && !mode_btn[0]) mode_d = M_CH2;
    else                                 mode_d = M_CH1;
  end

  assign chg    = mode_d != mode_q;
  assign tc     = (mode_q == M_CHOP) && (div_q == DW'(CHOP_DIV - 1));
  assign shared = (mode_d == M_ALT) || (mode_d == M_CHOP);

  always_comb begin
    sel_d = sel_q;
    div_d = '0;
    bl_d  = (bl_q != '0) ? bl_q - 1'b1 : '0;
    if (chg) begin
      sel_d = 1'b0;
      bl_d  = '0;
    end else if (mode_q == M_CHOP) begin
      if (tc) begin
        sel_d = ~sel_q;
        bl_d  = BW'(BLANK_W);
      end else begin
        div_d = div_q + 1'b1;
      end
    end else if (mode_q == M_ALT && sweep_end) begin
      sel_d = ~sel_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= M_CH1;
      sel_q    <= 1'b0;
      div_q    <= '0;
      bl_q     <= '0;
      ch1_en   <= 1'b1;
      ch2_en   <= 1'b0;
      ch2_inv  <= 1'b0;
      blank    <= 1'b0;
      trig_ch2 <= 1'b0;
    end else begin
      mode_q   <= mode_d;
      sel_q    <= sel_d;
      div_q    <= div_d;
      bl_q     <= bl_d;
      ch1_en   <= (mode_d == M_CH1) || (mode_d == M_DIFF) || (shared && !sel_d);
      ch2_en   <= (mode_d == M_CH2) || (mode_d == M_DIFF) || (shared && sel_d);
      ch2_inv  <= mode_d == M_DIFF;
      blank    <= bl_d != '0;
      trig_ch2 <= mode_btn[1] && (mode_d != M_CH1);
    end
  end
endmodule

module dual_trace_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic [4:0] mode_btn,
  input logic       sweep_end,
  input logic       ch1_en,
  input logic       ch2_en,
  input logic       ch2_inv,
  input logic       blank,
  input logic       trig_ch2
);
  // R4
  diff_both_chk: assert property (@(posedge clk) disable iff (rst)
    mode_btn[2] |=> (ch1_en && ch2_en && ch2_inv));
  // R2
  single_chan_chk: assert property (@(posedge clk) disable iff (rst)
    !ch2_inv |-> ($countones({ch1_en, ch2_en}) == 1));
  // R7
  alt_no_blank_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_btn[3] && !mode_btn[2]) |=> !blank);
  // R6
  blank_on_swap_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(blank) |-> (ch1_en != $past(ch1_en)));
  // R9
  ch1_trig_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_btn == 5'b00001) |=> !trig_ch2);
  // R3
  ch2_only_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_btn == 5'b00010) |=> (ch2_en && !ch1_en && trig_ch2));
endmodule

bind dual_trace_sequencer dual_trace_seq_chk u_chk (.*);

// File: tb/sim_dual_trace_sequencer.sv
module sim_dual_trace_sequencer;
  localparam int D = 8;
  localparam int W = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [4:0] mode_btn = 5'b00001;
  logic sweep_end = 1'b0;
  logic ch1_en, ch2_en, ch2_inv, blank, trig_ch2;

  int checks = 0, fails = 0;
  bit done = 0;

  int m_mode = 0, m_sel = 0, m_div = 0, m_brem = 0;
  bit m_trig = 0, m_chg = 0, m_sweep_side = 0;

  always #2 clk = ~clk;

  dual_trace_sequencer #(.CHOP_DIV(D), .BLANK_W(W)) u0 (
    .clk(clk), .rst(rst), .mode_btn(mode_btn), .sweep_end(sweep_end),
    .ch1_en(ch1_en), .ch2_en(ch2_en), .ch2_inv(ch2_inv),
    .blank(blank), .trig_ch2(trig_ch2));

  function automatic int decode(logic [4:0] b);
    if (b[2]) return 2;
    if (b[3]) return 3;
    if (b[4]) return 4;
    if (b[1] && !b[0]) return 1;
    return 0;
  endfunction

  task automatic chk(string tag, string name, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, name, act, exp, $time);
    end
  endtask

  task automatic step();
    int nm;
    @(posedge clk);
    nm = decode(mode_btn);
    m_chg = 0;
    m_sweep_side = sweep_end && (m_mode != 3);
    if (rst) begin
      m_mode = 0; m_sel = 0; m_div = 0; m_brem = 0; m_trig = 0;
    end else begin
      if (nm != m_mode) begin
        m_chg = 1; m_mode = nm; m_sel = 0; m_div = 0; m_brem = 0;
      end else if (m_mode == 4) begin
        if (m_brem > 0) m_brem--;
        if (m_div == D - 1) begin
          m_div = 0; m_sel ^= 1; m_brem = W;
        end else m_div++;
      end else begin
        if (m_brem > 0) m_brem--;
        if (m_mode == 3 && sweep_end) m_sel ^= 1;
      end
      m_trig = mode_btn[1] && (nm != 0);
    end
    @(negedge clk);
    begin
      string tg, tb;
      bit shared;
      shared = (m_mode == 3 || m_mode == 4);
      case (m_mode)
        0: tg = "R2"; 1: tg = "R3"; 2: tg = "R4"; 3: tg = "R7"; default: tg = "R5";
      endcase
      if (rst) tg = "R1";
      else if (m_chg) tg = "R10";
      else if (m_sweep_side) tg = "R8";
      else if (mode_btn[3] && mode_btn[4] && !mode_btn[2]) tg = "R11";
      tb = rst ? "R1" : (m_mode == 4 ? "R6" : (m_mode == 3 ? "R7" : "R10"));
      chk(tg, "ch1_en", ch1_en, (m_mode == 0 || m_mode == 2 || (shared && m_sel == 0)));
      chk(tg, "ch2_en", ch2_en, (m_mode == 1 || m_mode == 2 || (shared && m_sel == 1)));
      chk(tg, "ch2_inv", ch2_inv, m_mode == 2);
      chk(tb, "blank", blank, m_brem > 0);
      chk(rst ? "R1" : "R9", "trig_ch2", trig_ch2, m_trig);
    end
  endtask

  task automatic run(logic [4:0] b, int n, int sweep_every);
    mode_btn = b;
    for (int i = 0; i < n; i++) begin
      sweep_end = (sweep_every > 0) && (i % sweep_every == 0);
      step();
    end
    sweep_end = 1'b0;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #200000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < 3; i++) step();
    rst = 1'b0;
    run(5'b00001, 10, 3);
    run(5'b00010, 10, 4);
    run(5'b00011, 5, 2);
    run(5'b00000, 5, 0);
    run(5'b10000, 40, 5);
    run(5'b10010, 30, 0);
    for (int k = 0; k <= D + 1; k++) begin
      run(5'b10000, k, 0);
      run(5'b01000, 3, 1);
      run(5'b00001, 2, 0);
    end
    run(5'b01000, 30, 3);
    run(5'b01010, 20, 4);
    run(5'b00100, 8, 2);
    run(5'b01100, 8, 2);
    run(5'b10110, 12, 0);
    run(5'b11000, 20, 3);
    run(5'b10000, 12, 0);
    rst = 1'b1;
    step();
    rst = 1'b0;
    run(5'b10000, 25, 0);
    finish_up();
  end
endmodule